// File: doc/BRIEF.md
# Bit-Alias SRAM Bridge

This block is a memory-mapped slave that sits on a simple word bus. It serves two address windows. The first is a plain SRAM window, where each 32-bit bus word reads and writes 32 stored bits. The second is a bit-alias window, where every 32-bit bus word stands for exactly one stored bit of that same SRAM. Software can therefore flip a single flag with one bus write and never touch its neighbours.

An alias write is carried out inside the block as an atomic read-modify-write. The block reads the word that holds the target bit, then writes it back with only that bit changed. It holds off the bus for the duration, so no other access can slip in between. An alias read returns the addressed bit in bit 0, with zeros above it. An address in neither window is answered at once with zero data and an error flag, and nothing is stored.

The master drives `req_valid` together with the address, the write enable and the write data, and holds them until it sees `resp_ready` high at a rising clock edge. `resp_ready`, `resp_rdata` and `resp_err` are valid in that same cycle.

Top module: `bb_bridge`

## Requirements
- R1: A word read or write whose address lies in the SRAM window [0x2000_0000, 0x2000_2000) completes in one cycle, with `resp_ready` high in the first cycle that `req_valid` is high. A read returns the 32 bits last written to that word. Address bits 1:0 are ignored.
- R2: For an alias address A in [0x2200_0000, 0x2204_0000), let k = (A − 0x2200_0000) >> 2. The target is bit (k & 7) of SRAM byte (k >> 3). SRAM bytes are little-endian within a word: byte b sits in word b >> 2, at bits 8·(b & 3)+7 down to 8·(b & 3). So the target is word k >> 5, bit k & 31, and the last alias word 0x2203_FFFC maps to bit 31 of the last SRAM word.
- R3: An alias write sets the target bit when write-data bit 0 is 1 and clears it when bit 0 is 0. Every other stored bit stays as it was.
- R4: On an alias write, write-data bits 31:1 have no effect on storage.
- R5: An alias write takes exactly two cycles. `resp_ready` is low in the first cycle and high in the second, and the stored bit changes at the end of the second cycle.
- R6: An alias read completes in one cycle. It returns the target bit in `resp_rdata[0]` and zeros in bits 31:1.
- R7: An access outside both windows completes in one cycle, with `resp_ready` and `resp_err` high and `resp_rdata` zero. It changes no stored data. `resp_err` is low whenever the access hits a window or `req_valid` is low.
- R8: Both views stay coherent. A bit changed through the alias window shows in the next plain read of its word, and a plain write shows in the next alias reads of that word's bits.
- R9: When `rst_n` is low at a rising edge, the sequencer returns to idle and any pending alias write-back is dropped. After reset, with `req_valid` low, `resp_ready` and `resp_err` are low. SRAM contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present; held until accepted |
| req_addr | input | 32 | Byte address of the word access |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| resp_ready | output | 1 | Access completes at this rising edge |
| resp_rdata | output | 32 | Read data, valid while `resp_ready` is high |
| resp_err | output | 1 | Address hit no window, valid with `resp_ready` |

## Verification
The hardest state to reach from the ports is an alias write caught between its read phase and its write-back. To get there, the bench starts an alias write, lets one rising edge pass so the sequencer holds the fetched word, and then pulls reset low before the write-back edge. A plain read afterwards must show the word unchanged.

The other corners are driven with directed addresses: the last alias word and the last SRAM word; the addresses just outside each window edge; and alias writes whose upper data bits are the opposite of bit 0. Each of these is then read back through both views.

// File: rtl/bb_pkg.sv
// Package: shared types for the bit-alias bridge.
// Assumes: one request at a time; all accesses are 32-bit words.
package bb_pkg;
    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_SRAM  = 2'd1,
        RGN_ALIAS = 2'd2
    } region_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WBACK = 1'b1
    } seq_state_e;
endpackage

// File: rtl/bb_addr_decode.sv
// Module: bb_addr_decode
// Classifies a byte address as SRAM window, alias window or miss. It also gives
// the SRAM word index and, for alias hits, the bit position inside that word.
// Assumes: SRAM_BYTES is a power of two and a multiple of 4; base addresses
// are aligned to their window size.
module bb_addr_decode
    import bb_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] SRAM_BASE  = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000,
    parameter int              SRAM_BYTES = 8192,
    parameter int              IDX_W      = $clog2(SRAM_BYTES / 4)
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  word_idx,
    output logic [4:0]        bit_pos
);
    localparam logic [ADDR_W-1:0] SRAM_SPAN  = ADDR_W'(SRAM_BYTES);
    localparam logic [ADDR_W-1:0] ALIAS_SPAN = ADDR_W'(SRAM_BYTES) << 5;

    logic [ADDR_W-1:0] sram_off;
    logic [ADDR_W-1:0] alias_off;
    logic              sram_hit;
    logic              alias_hit;

    // Window offsets and hit tests
    always_comb begin
        sram_off  = addr - SRAM_BASE;
        alias_off = addr - ALIAS_BASE;
        sram_hit  = (addr >= SRAM_BASE) && (sram_off < SRAM_SPAN);
        alias_hit = (addr >= ALIAS_BASE) && (alias_off < ALIAS_SPAN);
    end

    // Region select and index translation (alias word k -> word k>>5, bit k&31)
    always_comb begin
        region   = RGN_NONE;
        word_idx = '0;
        bit_pos  = '0;
        if (sram_hit) begin
            region   = RGN_SRAM;
            word_idx = sram_off[2 +: IDX_W];
        end else if (alias_hit) begin
            region   = RGN_ALIAS;
            word_idx = alias_off[7 +: IDX_W];
            bit_pos  = alias_off[6:2];
        end
    end
endmodule

// File: rtl/bb_word_store.sv
// Module: bb_word_store
// Word-wide storage with one combinational read port and one synchronous
// write port. Contents are not reset.
// Assumes: the caller never needs read-during-write bypass.
module bb_word_store #(
    parameter int WORDS  = 2048,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] mem [WORDS];

    // Read port
    always_comb rd_data = mem[rd_idx];

    // Write port; writes are blocked while reset is held
    always_ff @(posedge clk) begin
        if (rst_n && wr_en) mem[wr_idx] <= wr_data;
    end
endmodule

// File: rtl/bb_rmw_seq.sv
// Module: bb_rmw_seq
// Bus response and access sequencer. Plain SRAM and alias reads finish in one
// cycle. An alias write captures the target word in IDLE, then writes it back
// with one bit changed in WBACK, holding ready low until then.
// Assumes: the master holds its request stable until ready is seen.
module bb_rmw_seq
    import bb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    input  region_e           region,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [4:0]        bit_pos,
    input  logic [DATA_W-1:0] rd_data,
    output logic              resp_ready,
    output logic              resp_err,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [DATA_W-1:0] mem_wdata
);
    seq_state_e        state;
    logic [DATA_W-1:0] hold_word;
    logic [IDX_W-1:0]  hold_idx;
    logic [4:0]        hold_bit;
    logic              hold_val;
    logic              start_rmw;

    // Detect the first phase of an alias write
    always_comb start_rmw = (state == SEQ_IDLE) && req_valid && req_we &&
                            (region == RGN_ALIAS);

    // State and captured-word registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            hold_word <= '0;
            hold_idx  <= '0;
            hold_bit  <= '0;
            hold_val  <= 1'b0;
        end else if (state == SEQ_WBACK) begin
            state <= SEQ_IDLE;
        end else if (start_rmw) begin
            state     <= SEQ_WBACK;
            hold_word <= rd_data;
            hold_idx  <= word_idx;
            hold_bit  <= bit_pos;
            hold_val  <= req_wdata[0];
        end
    end

    // Response and storage-write decode
    always_comb begin
        resp_ready = 1'b0;
        resp_err   = 1'b0;
        resp_rdata = '0;
        mem_we     = 1'b0;
        mem_idx    = word_idx;
        mem_wdata  = req_wdata;
        if (state == SEQ_WBACK) begin
            resp_ready          = 1'b1;
            mem_we              = 1'b1;
            mem_idx             = hold_idx;
            mem_wdata           = hold_word;
            mem_wdata[hold_bit] = hold_val;
        end else if (req_valid) begin
            unique case (region)
                RGN_SRAM: begin
                    resp_ready = 1'b1;
                    mem_we     = req_we;
                    if (!req_we) resp_rdata = rd_data;
                end
                RGN_ALIAS: begin
                    resp_ready = !req_we;
                    if (!req_we) resp_rdata = {{(DATA_W-1){1'b0}}, rd_data[bit_pos]};
                end
                default: begin
                    resp_ready = 1'b1;
                    resp_err   = 1'b1;
                end
            endcase
        end
    end

    // R5
    alias_wb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_rmw |=> (state == SEQ_WBACK) && resp_ready && mem_we);

    // R5
    wb_prev_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_WBACK) |-> $past(state == SEQ_IDLE && !resp_ready));

    // R3
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_WBACK) |-> ($countones(mem_wdata ^ hold_word) <= 1));

    // R1
    sram_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && req_valid && region == RGN_SRAM) |-> resp_ready && !resp_err);
endmodule

// File: rtl/bb_bridge.sv
// Module: bb_bridge (top)
// Bit-alias SRAM bridge: connects the address decoder, the sequencer and the
// word store. Alias word k maps to SRAM word k>>5, bit k&31.
// Assumes: a single outstanding request held by the master until ready.
module bb_bridge
    import bb_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 32,
    parameter int                SRAM_BYTES = 8192,
    parameter logic [ADDR_W-1:0] SRAM_BASE  = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_ready,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              resp_err
);
    localparam int WORDS = SRAM_BYTES / 4;
    localparam int IDX_W = $clog2(WORDS);

    region_e           region;
    logic [IDX_W-1:0]  word_idx;
    logic [4:0]        bit_pos;
    logic [DATA_W-1:0] rd_data;
    logic              mem_we;
    logic [IDX_W-1:0]  mem_idx;
    logic [DATA_W-1:0] mem_wdata;

    bb_addr_decode #(
        .ADDR_W(ADDR_W), .SRAM_BASE(SRAM_BASE), .ALIAS_BASE(ALIAS_BASE),
        .SRAM_BYTES(SRAM_BYTES), .IDX_W(IDX_W)
    ) u_decode (
        .addr(req_addr), .region(region), .word_idx(word_idx), .bit_pos(bit_pos)
    );

    bb_rmw_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_wdata(req_wdata), .region(region), .word_idx(word_idx),
        .bit_pos(bit_pos), .rd_data(rd_data), .resp_ready(resp_ready),
        .resp_err(resp_err), .resp_rdata(resp_rdata), .mem_we(mem_we),
        .mem_idx(mem_idx), .mem_wdata(mem_wdata)
    );

    bb_word_store #(.WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_idx(word_idx), .rd_data(rd_data),
        .wr_en(mem_we), .wr_idx(mem_idx), .wr_data(mem_wdata)
    );

    // R7
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && resp_err) |-> resp_ready && !mem_we && (resp_rdata == '0));

    // R7
    hit_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || region != RGN_NONE) |-> !resp_err);

    // R6
    alias_rd_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we && resp_ready && region == RGN_ALIAS) |->
        (resp_rdata[DATA_W-1:1] == '0));
endmodule

// File: tb/test_bb_bridge.sv
`timescale 1ns/1ps
module test_bb_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        resp_ready;
    logic [31:0] resp_rdata;
    logic        resp_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    localparam logic [31:0] SB = 32'h2000_0000;
    localparam logic [31:0] AB = 32'h2200_0000;

    bb_bridge i_bb_bridge (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata), .resp_ready(resp_ready),
        .resp_rdata(resp_rdata), .resp_err(resp_err)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus transfer; reports data, error and the cycles until ready
    task automatic xfer(input logic [31:0] a, input logic w, input logic [31:0] d,
                        output logic [31:0] rd, output logic e, output int cyc);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_we = w; req_wdata = d;
        cyc = 0; rd = '0; e = 1'b0;
        forever begin
            #1;
            cyc++;
            if (resp_ready) begin
                rd = resp_rdata; e = resp_err;
                @(posedge clk);
                break;
            end
            if (cyc > 20) break;
            @(posedge clk);
        end
        #1 req_valid = 1'b0;
    endtask

    function automatic logic [31:0] alias_addr(input int word, input int bitn);
        return AB + 32'((word * 32 + bitn) * 4);
    endfunction

    task automatic t_reset();
        #1;
        chk(resp_ready === 1'b0 && resp_err === 1'b0, "R9 idle after reset",
            {30'b0, resp_ready, resp_err}, 32'h0);
    endtask

    task automatic t_sram();
        logic [31:0] rd; logic e; int c;
        xfer(SB + 0, 1, 32'hA5C3_0F81, rd, e, c);
        chk(c == 1 && !e, "R1 sram write one cycle", 32'(c), 32'd1);
        xfer(SB + 4, 1, 32'h1234_5678, rd, e, c);
        xfer(32'h2000_1FFC, 1, 32'h0000_0000, rd, e, c);
        xfer(SB + 0, 0, 0, rd, e, c);
        chk(rd == 32'hA5C3_0F81 && c == 1, "R1 sram read word0", rd, 32'hA5C3_0F81);
        xfer(SB + 7, 0, 0, rd, e, c);
        chk(rd == 32'h1234_5678, "R1 sram read low bits ignored", rd, 32'h1234_5678);
    endtask

    task automatic t_alias_read();
        logic [31:0] rd; logic e; int c;
        logic [31:0] pat = 32'hA5C3_0F81;
        int bad = 0;
        for (int b = 0; b < 32; b++) begin
            xfer(alias_addr(0, b), 0, 0, rd, e, c);
            if (rd != {31'b0, pat[b]} || c != 1 || e) bad++;
        end
        chk(bad == 0, "R6 alias read all bits of word0", 32'(bad), 32'd0);
        xfer(alias_addr(1, 13), 0, 0, rd, e, c);
        chk(rd == 32'h0000_0000, "R2 word1 bit13 (byte5 bit5)", rd, 32'h0);
        xfer(alias_addr(1, 12), 0, 0, rd, e, c);
        chk(rd == 32'h0000_0001, "R2 word1 bit12 (byte5 bit4)", rd, 32'h1);
    endtask

    task automatic t_alias_write();
        logic [31:0] rd; logic e; int c;
        xfer(alias_addr(0, 1), 1, 32'h1, rd, e, c);
        chk(c == 2, "R5 alias write two cycles", 32'(c), 32'd2);
        xfer(SB + 0, 0, 0, rd, e, c);
        chk(rd == 32'hA5C3_0F83, "R3 R8 alias set visible in plain read", rd, 32'hA5C3_0F83);
        xfer(alias_addr(0, 31), 1, 32'h0, rd, e, c);
        xfer(SB + 0, 0, 0, rd, e, c);
        chk(rd == 32'h25C3_0F83, "R3 alias clear bit31", rd, 32'h25C3_0F83);
        xfer(alias_addr(2047, 31), 1, 32'h1, rd, e, c);
        xfer(32'h2000_1FFC, 0, 0, rd, e, c);
        chk(rd == 32'h8000_0000, "R2 last alias word hits last bit", rd, 32'h8000_0000);
    endtask

    task automatic t_ignore_upper();
        logic [31:0] rd; logic e; int c;
        xfer(alias_addr(1, 0), 1, 32'hFFFF_FFFE, rd, e, c);
        xfer(alias_addr(1, 2), 1, 32'h0000_0001, rd, e, c);
        xfer(alias_addr(1, 3), 1, 32'hFFFF_FFFF, rd, e, c);
        xfer(SB + 4, 0, 0, rd, e, c);
        chk(rd == 32'h1234_567C, "R4 upper write bits ignored", rd, 32'h1234_567C);
    endtask

    task automatic t_coherent();
        logic [31:0] rd; logic e; int c;
        xfer(SB + 8, 1, 32'h0000_8000, rd, e, c);
        xfer(alias_addr(2, 15), 0, 0, rd, e, c);
        chk(rd == 32'h1, "R8 plain write seen via alias (set)", rd, 32'h1);
        xfer(alias_addr(2, 14), 0, 0, rd, e, c);
        chk(rd == 32'h0, "R8 plain write seen via alias (clear)", rd, 32'h0);
    endtask

    task automatic t_miss();
        logic [31:0] rd; logic e; int c;
        xfer(32'h2000_2000, 1, 32'hFFFF_FFFF, rd, e, c);
        chk(e && c == 1, "R7 write past sram end flagged", {31'b0, e}, 32'h1);
        xfer(32'h1FFF_FFFC, 0, 0, rd, e, c);
        chk(e && rd == 0 && c == 1, "R7 read below sram returns 0", rd, 32'h0);
        xfer(32'h2204_0000, 1, 32'h1, rd, e, c);
        chk(e && c == 1, "R7 write past alias end flagged", {31'b0, e}, 32'h1);
        xfer(32'h21FF_FFFC, 1, 32'h0, rd, e, c);
        xfer(SB + 0, 0, 0, rd, e, c);
        chk(rd == 32'h25C3_0F83 && !e, "R7 no state change word0", rd, 32'h25C3_0F83);
        xfer(32'h2000_1FFC, 0, 0, rd, e, c);
        chk(rd == 32'h8000_0000, "R7 no state change last word", rd, 32'h8000_0000);
    endtask

    task automatic t_reset_mid_write();
        logic [31:0] rd; logic e; int c;
        @(negedge clk);
        req_valid = 1'b1; req_addr = alias_addr(0, 2); req_we = 1'b1; req_wdata = 32'h1;
        @(posedge clk);
        #1 rst_n = 1'b0;
        chk(resp_ready === 1'b1, "R9 write-back phase reached", {31'b0, resp_ready}, 32'h1);
        @(posedge clk);
        #1 req_valid = 1'b0; rst_n = 1'b1;
        #0.5;
        chk(resp_ready === 1'b0, "R9 sequencer idle after reset", {31'b0, resp_ready}, 32'h0);
        xfer(SB + 0, 0, 0, rd, e, c);
        chk(rd == 32'h25C3_0F83, "R9 pending write-back dropped", rd, 32'h25C3_0F83);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_sram();
        t_alias_read();
        t_alias_write();
        t_ignore_upper();
        t_coherent();
        t_miss();
        t_reset_mid_write();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end
endmodule